// File: doc/BRIEF.md
# Byte-Port Frame Network Interface

This block links a host bus to a pair of byte streams and carries whole network frames between them. The host sees a small register window. To send, it programs a frame length and then writes the frame one byte at a time into a single data port. The block holds the bytes in a transmit buffer. When the final byte lands, it plays the frame out on a byte stream with an end-of-frame marker.

In the other direction, a frame arriving on the input stream is either taken whole into a receive buffer or dropped whole. The host learns the length from a count register and pulls the bytes out through a read port. A single busy flag covers both directions. Two cause bits, each cleared by writing 1 to it, drive a level interrupt.

The block decodes only the low six address bits; decoding the window's base is left to the surrounding bus logic. Reads return data right-aligned, one cycle after the read strobe. Writes use the low bits of the write data, so 1-, 2- and 4-byte accesses all behave the same.

Top module: `frame_port_nic`

## Requirements
- R1: A read strobe returns its data on `bus_rdata` in the following cycle. Offset 0x00 reads 0x4D495053, offset 0x04 reads 0x4E455430, and offsets with no register (for example 0x24 and 0x3C) read 0.
- R2: A write to the length register at offset 0x10 stores the value when it is at most MAX_FRAME (1514) and stores 0 otherwise. Reading offset 0x10 returns the stored length.
- R3: Each write to the transmit data port at offset 0x18 stores bits 7:0 at the current write index and then advances the index. The write that makes the index equal the programmed length starts emission. The frame then appears on `tx_data` with `tx_valid` high for exactly length consecutive cycles, in write order, with `tx_last` high only on the final byte.
- R4: The write that starts emission clears the length register and the write index, sets cause bit 0 (transmit done) and sets busy. Offset 0x08 reads busy in bit 0.
- R5: An incoming frame whose first beat arrives while busy is set, or while the receive count is nonzero, is dropped whole. The count, the cause bits and busy stay unchanged.
- R6: An accepted frame sets the receive count at offset 0x0C to its byte count, sets busy and sets cause bit 1 (receive done). Bytes beyond MAX_FRAME are discarded and the count saturates at MAX_FRAME.
- R7: Each read of offset 0x14 returns the next stored receive byte in arrival order and decrements the receive count. With the count at 0, the read returns 0 and changes nothing.
- R8: `irq` is high exactly while at least one cause bit is set.
- R9: A write to offset 0x20 clears each cause bit whose data bit is 1 and always clears busy. A cause bit being set in the same cycle takes precedence over the clear.
- R10: After reset, busy, both counts, the length register and both cause bits read 0, `irq` is low and `tx_valid` is low.
- R11: Transmit data writes made once the write index has reached MAX_FRAME are dropped. A length of 0 therefore never starts emission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tx_valid | output | 1 | Outgoing frame byte valid |
| tx_data | output | 8 | Outgoing frame byte |
| tx_last | output | 1 | Final byte of the outgoing frame |
| rx_valid | input | 1 | Incoming frame byte valid |
| rx_data | input | 8 | Incoming frame byte |
| rx_last | input | 1 | Final byte of the incoming frame |
| irq | output | 1 | Level interrupt, high while any cause bit is set |

## Verification
The properties assume that `bus_wr` and `bus_rd` are never high together and that every incoming frame ends with a beat carrying `rx_last`. They also assume the host does not write the transmit data port while a frame is still being played out. The bench drives one bus access at a time from tasks and sends each incoming frame as an unbroken run of beats with a closing marker. Before each new transmit frame it waits until the previous one has left the stream. Random frame lengths and byte values come from a fixed seed; directed cases cover oversize lengths, refused frames, truncation and a transmit index stuck at capacity.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    localparam logic [31:0] ID_WORD_HI = 32'h4D49_5053;
    localparam logic [31:0] ID_WORD_LO = 32'h4E45_5430;

    localparam logic [5:0] OFF_ID_HI  = 6'h00;
    localparam logic [5:0] OFF_ID_LO  = 6'h04;
    localparam logic [5:0] OFF_BUSY   = 6'h08;
    localparam logic [5:0] OFF_RX_CNT = 6'h0C;
    localparam logic [5:0] OFF_TX_LEN = 6'h10;
    localparam logic [5:0] OFF_RX_DAT = 6'h14;
    localparam logic [5:0] OFF_TX_DAT = 6'h18;
    localparam logic [5:0] OFF_CAUSE  = 6'h20;

    localparam int CAUSE_TX = 0;
    localparam int CAUSE_RX = 1;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [5:0]  off;
        logic [31:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic rx_done;
        logic tx_done;
    } cause_t;

    function automatic logic hit(input bus_req_t r, input logic [5:0] off);
        return r.off == off;
    endfunction

endpackage

// File: rtl/fpn_tx_path.sv
module fpn_tx_path
    import fpn_pkg::*;
#(
    parameter int MAX_FRAME = 1514
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              len_wr,
    input  logic [31:0]                       len_wdata,
    input  logic                              dat_wr,
    input  logic [7:0]                        dat_byte,
    output logic [$clog2(MAX_FRAME+1)-1:0]    len_q,
    output logic                              done,
    output logic                              tx_valid,
    output logic [7:0]                        tx_data,
    output logic                              tx_last
);
    localparam int LEN_W = $clog2(MAX_FRAME + 1);
    localparam int IDX_W = $clog2(MAX_FRAME);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_FRAME);

    logic [7:0]       buf_mem [0:MAX_FRAME-1];
    logic [LEN_W-1:0] wr_idx;
    logic [LEN_W-1:0] snd_ptr;
    logic [LEN_W-1:0] snd_len;
    logic             sending;

    logic store_ok;
    logic hit_len;

    assign store_ok = dat_wr && !sending && (wr_idx < CAP);
    assign hit_len  = (wr_idx + LEN_W'(1)) == len_q;
    assign done     = store_ok && hit_len;

    always_ff @(posedge clk) begin
        if (store_ok) begin
            buf_mem[wr_idx[IDX_W-1:0]] <= dat_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q    <= '0;
            wr_idx   <= '0;
            snd_ptr  <= '0;
            snd_len  <= '0;
            sending  <= 1'b0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_last  <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            if (sending) begin
                tx_valid <= 1'b1;
                tx_data  <= buf_mem[snd_ptr[IDX_W-1:0]];
                tx_last  <= (snd_ptr == snd_len - LEN_W'(1));
                if (snd_ptr == snd_len - LEN_W'(1)) begin
                    sending <= 1'b0;
                end else begin
                    snd_ptr <= snd_ptr + LEN_W'(1);
                end
            end
            if (len_wr) begin
                len_q <= (len_wdata <= 32'(MAX_FRAME)) ? len_wdata[LEN_W-1:0] : '0;
            end
            if (store_ok) begin
                if (hit_len) begin
                    snd_len <= len_q;
                    snd_ptr <= '0;
                    sending <= 1'b1;
                    len_q   <= '0;
                    wr_idx  <= '0;
                end else begin
                    wr_idx <= wr_idx + LEN_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/fpn_rx_path.sv
module fpn_rx_path
    import fpn_pkg::*;
#(
    parameter int MAX_FRAME = 1514
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              rx_valid,
    input  logic [7:0]                        rx_data,
    input  logic                              rx_last,
    input  logic                              can_take,
    input  logic                              rd_pop,
    output logic [$clog2(MAX_FRAME+1)-1:0]    cnt,
    output logic [7:0]                        rd_byte,
    output logic                              done
);
    localparam int LEN_W = $clog2(MAX_FRAME + 1);
    localparam int IDX_W = $clog2(MAX_FRAME);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_FRAME);

    logic [7:0]       buf_mem [0:MAX_FRAME-1];
    logic [LEN_W-1:0] wr_idx;
    logic [LEN_W-1:0] rd_idx;
    logic             in_frame;
    logic             capturing;

    logic             first_beat;
    logic             take_first;
    logic             take;
    logic [LEN_W-1:0] pos;
    logic             room;
    logic             pop_ok;

    assign first_beat = rx_valid && !in_frame;
    assign take_first = first_beat && can_take && (cnt == '0);
    assign take       = take_first || (rx_valid && in_frame && capturing);
    assign pos        = take_first ? '0 : wr_idx;
    assign room       = pos < CAP;
    assign done       = take && rx_last;
    assign pop_ok     = rd_pop && (cnt != '0);
    assign rd_byte    = ((cnt != '0) && (rd_idx < CAP)) ? buf_mem[rd_idx[IDX_W-1:0]] : 8'h00;

    always_ff @(posedge clk) begin
        if (take && room) begin
            buf_mem[pos[IDX_W-1:0]] <= rx_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame  <= 1'b0;
            capturing <= 1'b0;
            wr_idx    <= '0;
            rd_idx    <= '0;
            cnt       <= '0;
        end else begin
            if (rx_valid) begin
                in_frame  <= !rx_last;
                capturing <= take && !rx_last;
            end
            if (take) begin
                wr_idx <= room ? pos + LEN_W'(1) : pos;
            end
            if (done) begin
                cnt    <= room ? pos + LEN_W'(1) : pos;
                rd_idx <= '0;
            end else if (pop_ok) begin
                cnt    <= cnt - LEN_W'(1);
                rd_idx <= rd_idx + LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/fpn_status.sv
module fpn_status
    import fpn_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tx_done,
    input  logic   rx_done,
    input  logic   ack_wr,
    input  logic [1:0] ack_bits,
    output logic   busy,
    output cause_t cause
);
    cause_t set_v;
    cause_t clr_v;

    assign set_v = '{rx_done: rx_done, tx_done: tx_done};
    assign clr_v = ack_wr ? cause_t'(ack_bits) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cause <= '0;
        end else begin
            cause <= (cause & ~clr_v) | set_v;
            busy  <= (busy && !ack_wr) || tx_done || rx_done;
        end
    end

endmodule

// File: rtl/frame_port_nic.sv
module frame_port_nic
    import fpn_pkg::*;
#(
    parameter int MAX_FRAME = 1514
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        irq
);
    localparam int LEN_W = $clog2(MAX_FRAME + 1);

    bus_req_t         req;
    logic [LEN_W-1:0] tx_len;
    logic [LEN_W-1:0] rx_count;
    logic [7:0]       rx_byte;
    logic             tx_done;
    logic             rx_done;
    logic             busy;
    cause_t           cause;

    assign req = '{wr: bus_wr, rd: bus_rd, off: bus_addr, wdata: bus_wdata};

    fpn_tx_path #(.MAX_FRAME(MAX_FRAME)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .len_wr    (req.wr && hit(req, OFF_TX_LEN)),
        .len_wdata (req.wdata),
        .dat_wr    (req.wr && hit(req, OFF_TX_DAT)),
        .dat_byte  (req.wdata[7:0]),
        .len_q     (tx_len),
        .done      (tx_done),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last)
    );

    fpn_rx_path #(.MAX_FRAME(MAX_FRAME)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_last  (rx_last),
        .can_take (!busy),
        .rd_pop   (req.rd && hit(req, OFF_RX_DAT)),
        .cnt      (rx_count),
        .rd_byte  (rx_byte),
        .done     (rx_done)
    );

    fpn_status u_status (
        .clk      (clk),
        .rst      (rst),
        .tx_done  (tx_done),
        .rx_done  (rx_done),
        .ack_wr   (req.wr && hit(req, OFF_CAUSE)),
        .ack_bits (req.wdata[1:0]),
        .busy     (busy),
        .cause    (cause)
    );

    assign irq = |cause;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (req.rd) begin
            case (req.off)
                OFF_ID_HI:  bus_rdata <= ID_WORD_HI;
                OFF_ID_LO:  bus_rdata <= ID_WORD_LO;
                OFF_BUSY:   bus_rdata <= {31'd0, busy};
                OFF_RX_CNT: bus_rdata <= 32'(rx_count);
                OFF_TX_LEN: bus_rdata <= 32'(tx_len);
                OFF_RX_DAT: bus_rdata <= {24'd0, rx_byte};
                OFF_CAUSE:  bus_rdata <= {30'd0, cause};
                default:    bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/fpn_chk.sv
module fpn_chk #(
    parameter int MAX_FRAME = 1514
) (
    input logic                           clk,
    input logic                           rst,
    input logic [5:0]                     bus_addr,
    input logic                           bus_rd,
    input logic [31:0]                    bus_rdata,
    input logic                           tx_valid,
    input logic                           tx_last,
    input logic                           irq,
    input logic                           busy,
    input logic [1:0]                     cause,
    input logic [$clog2(MAX_FRAME+1)-1:0] rx_count,
    input logic [$clog2(MAX_FRAME+1)-1:0] tx_len,
    input logic                           tx_done,
    input logic                           rx_done
);
    // R1
    id_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 6'h00) |=> (bus_rdata == 32'h4D49_5053));

    // R2
    tx_len_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(tx_len) <= 32'(MAX_FRAME)));

    // R3
    tx_last_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    // R3
    tx_frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tx_last |=> !tx_valid);

    // R4
    tx_done_flags_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> (busy && cause[0] && tx_len == '0));

    // R5
    rx_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count != '0) |-> !rx_done);

    // R6
    rx_done_flags_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> (busy && cause[1] && rx_count != '0));

    // R6
    rx_count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(rx_count) <= 32'(MAX_FRAME)));

    // R8
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tx_done || rx_done));

endmodule

bind frame_port_nic fpn_chk #(.MAX_FRAME(MAX_FRAME)) u_fpn_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .irq       (irq),
    .busy      (busy),
    .cause     (cause),
    .rx_count  (rx_count),
    .tx_len    (tx_len),
    .tx_done   (tx_done),
    .rx_done   (rx_done)
);

// File: tb/frame_port_nic_bench.sv
`timescale 1ns/100ps
module frame_port_nic_bench;
    localparam int MAX = 1514;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0] cap [0:2047];
    int cap_n = 0;
    int last_n = 0;
    int last_pos = -1;
    logic [7:0] exp_b [0:2047];

    always #2.5 clk = ~clk;

    frame_port_nic #(.MAX_FRAME(MAX)) u_frame_port_nic (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .irq(irq)
    );

    always @(negedge clk) begin
        if (!rst && tx_valid) begin
            if (cap_n < 2048) cap[cap_n] = tx_data;
            if (tx_last) begin
                last_n++;
                last_pos = cap_n;
            end
            cap_n++;
        end
    end

    function automatic int exp_len(input logic [31:0] v);
        return (v <= 32'(MAX)) ? int'(v) : 0;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(input logic [5:0] off, input logic [31:0] d);
        bus_addr = off; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] off, output logic [31:0] d);
        bus_addr = off; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic send_rx(input int n, input int salt);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = 8'((i * 7 + salt) & 8'hFF);
            rx_last  = (i == n - 1);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
        @(negedge clk);
    endtask

    task automatic tx_frame(input int len);
        logic [31:0] v;
        int base;
        int bad;
        base = cap_n;
        wr(6'h10, 32'(len));
        for (int i = 0; i < len; i++) begin
            exp_b[i] = 8'($urandom);
            wr(6'h18, {$urandom, exp_b[i]} >> 0 & 32'hFFFF_FF00 | 32'(exp_b[i]));
            if (i == len - 2) check(cap_n == base, "R3 no early emit", cap_n - base, 0);
        end
        repeat (len + 4) @(negedge clk);
        check(cap_n - base == len, "R3 frame byte count", cap_n - base, len);
        bad = 0;
        for (int i = 0; i < len; i++) if (cap[base + i] != exp_b[i]) bad++;
        check(bad == 0, "R3 frame bytes", bad, 0);
        check(last_pos == base + len - 1, "R3 last marker position", last_pos, base + len - 1);
        rd(6'h10, v); check(v == 0, "R4 length cleared", v, 0);
        rd(6'h08, v); check(v == 1, "R4 busy set", v, 1);
        rd(6'h20, v); check(v[0] == 1'b1, "R4 tx cause set", v, 1);
        check(irq == 1'b1, "R8 irq with cause", irq, 1);
        wr(6'h20, 32'h1);
        rd(6'h20, v); check(v == 0, "R9 cause cleared", v, 0);
        rd(6'h08, v); check(v == 0, "R9 busy cleared", v, 0);
        check(irq == 1'b0, "R8 irq low", irq, 0);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        int bad;
        int base;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        rd(6'h08, v); check(v == 0, "R10 busy", v, 0);
        rd(6'h0C, v); check(v == 0, "R10 rx count", v, 0);
        rd(6'h10, v); check(v == 0, "R10 tx length", v, 0);
        rd(6'h20, v); check(v == 0, "R10 cause", v, 0);
        check(irq == 0 && tx_valid == 0, "R10 outputs", {irq, tx_valid}, 0);

        // R1 identifier and unused offsets
        rd(6'h00, v); check(v == 32'h4D49_5053, "R1 id hi", v, 32'h4D49_5053);
        rd(6'h04, v); check(v == 32'h4E45_5430, "R1 id lo", v, 32'h4E45_5430);
        rd(6'h24, v); check(v == 0, "R1 unused 0x24", v, 0);
        rd(6'h3C, v); check(v == 0, "R1 unused 0x3C", v, 0);

        // R2 length clipping
        wr(6'h10, 32'd1515); rd(6'h10, v); check(v == exp_len(1515), "R2 oversize", v, exp_len(1515));
        wr(6'h10, 32'hFFFF_0005); rd(6'h10, v); check(v == exp_len(32'hFFFF_0005), "R2 huge", v, 0);
        wr(6'h10, 32'd1514); rd(6'h10, v); check(v == exp_len(1514), "R2 max", v, 1514);
        wr(6'h10, 32'd0);

        // R3 R4 R8 R9 transmit: directed length 1, then random lengths
        tx_frame(1);
        for (int f = 0; f < 4; f++) tx_frame(2 + int'($urandom % 40));

        // R6 receive accepted
        n = 3 + int'($urandom % 30);
        send_rx(n, 11);
        rd(6'h0C, v); check(v == n, "R6 rx count", v, n);
        rd(6'h08, v); check(v == 1, "R6 busy", v, 1);
        rd(6'h20, v); check(v == 2, "R6 rx cause", v, 2);
        check(irq == 1, "R8 irq on rx", irq, 1);

        // R5 refused while busy
        send_rx(5, 99);
        rd(6'h0C, v); check(v == n, "R5 refused busy", v, n);

        // R9 write of zero clears busy only
        wr(6'h20, 32'h0);
        rd(6'h08, v); check(v == 0, "R9 busy by ack", v, 0);
        rd(6'h20, v); check(v == 2, "R9 cause kept", v, 2);

        // R5 refused while count nonzero
        send_rx(6, 55);
        rd(6'h0C, v); check(v == n, "R5 refused count", v, n);
        rd(6'h08, v); check(v == 0, "R5 busy unchanged", v, 0);

        // R7 drain in order
        bad = 0;
        for (int i = 0; i < n; i++) begin
            rd(6'h14, v);
            if (v != 32'((i * 7 + 11) & 8'hFF)) bad++;
        end
        check(bad == 0, "R7 drain bytes", bad, 0);
        rd(6'h0C, v); check(v == 0, "R7 count zero", v, 0);
        rd(6'h14, v); check(v == 0, "R7 empty read", v, 0);
        rd(6'h0C, v); check(v == 0, "R7 empty no change", v, 0);
        wr(6'h20, 32'h3);
        check(irq == 0, "R8 irq cleared", irq, 0);

        // R6 truncation to capacity
        send_rx(MAX + 5, 3);
        rd(6'h0C, v); check(v == MAX, "R6 truncated count", v, MAX);
        rd(6'h14, v); check(v == 32'(3), "R6 first byte", v, 3);
        rd(6'h14, v); check(v == 32'(10), "R6 second byte", v, 10);
        rd(6'h0C, v); check(v == MAX - 2, "R7 count decrement", v, MAX - 2);
        wr(6'h20, 32'h3);

        // R11 length zero fills index to capacity, later writes dropped
        base = cap_n;
        wr(6'h10, 32'd0);
        for (int i = 0; i < MAX + 2; i++) wr(6'h18, 32'(i));
        repeat (4) @(negedge clk);
        check(cap_n == base, "R11 no emit with zero length", cap_n - base, 0);
        wr(6'h10, 32'd5);
        for (int i = 0; i < 5; i++) wr(6'h18, 32'(i));
        repeat (10) @(negedge clk);
        check(cap_n == base, "R11 dropped at capacity", cap_n - base, 0);
        rd(6'h20, v); check(v == 0, "R11 no tx cause", v, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule